// File: doc/BRIEF.md
# Multi-channel DAC register update controller

This block holds the digital side of an eight-channel converter front end. It receives complete 24-bit command words, one per cycle when `cmd_valid` is high. For each channel it keeps a 16-bit staging register and a 16-bit live register, and it drives the live values out on a flat bus. A pending register stages a value without touching the output. A later transfer, picked by an 8-bit channel mask, moves staged values to the live registers all at once. A direct write skips the staging step.

An active-low load strobe (`load_n`) may arrive from outside the clock domain. The block synchronises it through two flops, and the synchronised level is then evaluated every cycle. While it is low, staged writes pass straight through to the live register. If the frame select is also high, every staging register is copied to its live register on each such cycle. The block also holds a single chain-mode flag. Each channel gives a one-cycle pulse whenever its live value actually changes.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset all live registers, staging registers, the chain flag and all update pulses are zero.
- R2: The command word is laid out as opcode in bits 23:20, channel in bits 19:16 and data in bits 15:0. Opcode 4'h1 stores the data in the addressed staging register only. With the synchronised strobe high, the live registers keep their values.
- R3: When opcode 4'h1 is applied while the synchronised strobe is low, the addressed live register also takes the data at the same clock edge.
- R4: Opcode 4'h2 copies the staging register to the live register for every channel n whose data bit n (bits 7:0) is 1. The other channels keep their values.
- R5: Opcode 4'h3 writes the data straight into the addressed live register, whatever the level of the strobe. The staging register is left unchanged.
- R6: At every clock edge where the synchronised strobe is low and `frame_sel` is high, all eight staging registers are copied to their live registers. With `frame_sel` low, this copy does not take place.
- R7: Opcode 4'h8 loads data bit 0 into the chain flag. 0 means standalone and 1 means chain mode. The flag is shown on `chain_mode`.
- R8: Opcodes 4'h1 and 4'h3 with a channel field of 8 to 15 change no register.
- R9: Any opcode other than 4'h1, 4'h2, 4'h3 and 4'h8 changes no register.
- R10: Bit n of `upd_pulse` is high for exactly the one cycle in which a new value of live register n first shows on `act_flat`. It stays low when a write leaves that value the same.
- R11: A level on `load_n` takes effect at the third rising clock edge after it is set up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd_word | input | 24 | Opcode, channel and data |
| frame_sel | input | 1 | Frame select, high between frames (synchronous) |
| load_n | input | 1 | Active-low load strobe, asynchronous |
| act_flat | output | 128 | Live registers, channel n in bits 16n+15:16n |
| upd_pulse | output | 8 | One-cycle change pulse per channel |
| chain_mode | output | 1 | Chain flag |

## Verification
A cycle-accurate model in the bench predicts every live value, pulse and the chain flag on every cycle. The stimulus first stages values and then reveals them with sparse, dense and empty masks. These show whether the staging store is really kept apart from the live registers. Direct writes are issued with the strobe both high and low, which separates write-through from transparency. Out-of-range channels, unknown opcodes and rewrites of equal values must all leave the outputs quiet. Strobe pulses with `frame_sel` high and low expose any wrong gating of the global copy and any wrong synchroniser latency.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned CH_W   = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned WORD_W = OP_W + CH_W + DATA_W;

  typedef enum logic [OP_W-1:0] {
    OP_STAGE  = 4'h1,
    OP_XFER   = 4'h2,
    OP_DIRECT = 4'h3,
    OP_CHAIN  = 4'h8
  } op_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [CH_W-1:0]   ch;
    logic [DATA_W-1:0] data;
  } word_t;
endpackage

// File: rtl/dacu_sync.sv
module dacu_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/dacu_decode.sv
module dacu_decode
  import dacu_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              ld_low,
  input  logic              frame_sel,
  output logic [N_CH-1:0]   wr_stage,
  output logic [N_CH-1:0]   wr_live,
  output logic [N_CH-1:0]   xfer,
  output logic              chain_we,
  output logic              chain_d,
  output logic [DATA_W-1:0] wdata
);
  word_t w;

  always_comb begin
    w        = word_t'(cmd_word);
    wdata    = w.data;
    chain_d  = w.data[0];
    chain_we = 1'b0;
    wr_stage = '0;
    wr_live  = '0;
    xfer     = {N_CH{ld_low & frame_sel}};
    if (cmd_valid) begin
      case (w.op)
        OP_STAGE: begin
          for (int i = 0; i < N_CH; i++) begin
            if (w.ch == CH_W'(i)) begin
              wr_stage[i] = 1'b1;
              wr_live[i]  = ld_low;
            end
          end
        end
        OP_XFER:   xfer = xfer | w.data[N_CH-1:0];
        OP_DIRECT: begin
          for (int i = 0; i < N_CH; i++) begin
            if (w.ch == CH_W'(i)) wr_live[i] = 1'b1;
          end
        end
        OP_CHAIN:  chain_we = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/dacu_chan.sv
module dacu_chan
  import dacu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stage,
  input  logic              wr_live,
  input  logic              xfer,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] live_q,
  output logic              upd_q
);
  logic [DATA_W-1:0] stage_q, stage_d, live_d;
  logic              stage_en, live_en, upd_d;

  always_comb begin
    stage_en = wr_stage;
    stage_d  = wdata;
    live_en  = wr_live | xfer;
    live_d   = wr_live ? wdata : stage_q;
    upd_d    = live_en && (live_d != live_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else if (live_en) live_q <= live_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_d;
  end
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dacu_pkg::*;
#(
  parameter int unsigned N_CH     = 8,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [WORD_W-1:0]      cmd_word,
  input  logic                   frame_sel,
  input  logic                   load_n,
  output logic [N_CH*DATA_W-1:0] act_flat,
  output logic [N_CH-1:0]        upd_pulse,
  output logic                   chain_mode
);
  logic              rst_sync_n;
  logic              load_s;
  logic              ld_low;
  logic [N_CH-1:0]   wr_stage, wr_live, xfer;
  logic              chain_we, chain_d, chain_q, chain_nx;
  logic [DATA_W-1:0] wdata;

  dacu_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  dacu_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_load_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(load_n), .q(load_s)
  );

  assign ld_low = ~load_s;

  dacu_decode #(.N_CH(N_CH)) u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .ld_low(ld_low),
    .frame_sel(frame_sel), .wr_stage(wr_stage), .wr_live(wr_live),
    .xfer(xfer), .chain_we(chain_we), .chain_d(chain_d), .wdata(wdata)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dacu_chan u_ch (
      .clk(clk), .rst_n(rst_sync_n),
      .wr_stage(wr_stage[g]), .wr_live(wr_live[g]), .xfer(xfer[g]),
      .wdata(wdata),
      .live_q(act_flat[g*DATA_W +: DATA_W]),
      .upd_q(upd_pulse[g])
    );
  end

  always_comb begin
    chain_nx = chain_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chain_q <= 1'b0;
    else if (chain_we) chain_q <= chain_nx;
  end

  assign chain_mode = chain_q;
endmodule

// File: rtl/dacu_checker.sv
module dacu_checker
  import dacu_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   cmd_valid,
  input logic [WORD_W-1:0]      cmd_word,
  input logic                   ld_low,
  input logic [N_CH*DATA_W-1:0] act_flat,
  input logic [N_CH-1:0]        upd_pulse,
  input logic                   chain_mode
);
  logic [OP_W-1:0] op;
  logic [CH_W-1:0] ch;
  logic            known_op;
  assign op = cmd_word[WORD_W-1 -: OP_W];
  assign ch = cmd_word[DATA_W +: CH_W];
  assign known_op = (op == 4'h1) || (op == 4'h2) || (op == 4'h3) || (op == 4'h8);

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (act_flat == '0 && upd_pulse == '0 && !chain_mode));

  // R2
  a_r2_stage_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && op == 4'h1 && !ld_low) |=> $stable(act_flat));

  // R7
  a_r7_chain_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && op == 4'h8) |=> (chain_mode == $past(cmd_word[0])));

  // R8
  a_r8_bad_channel: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && (op == 4'h1 || op == 4'h3) && ch >= CH_W'(N_CH) && !ld_low)
    |=> $stable(act_flat));

  // R9
  a_r9_unknown_op: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && !known_op && !ld_low) |=> ($stable(act_flat) && $stable(chain_mode)));

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    // R5
    a_r5_direct_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cmd_valid && op == 4'h3 && ch == CH_W'(g))
      |=> (act_flat[g*DATA_W +: DATA_W] == $past(cmd_word[DATA_W-1:0])));
    // R10
    a_r10_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_sync_n)
      upd_pulse[g] |-> !$stable(act_flat[g*DATA_W +: DATA_W]));
  end
endmodule

bind dac_update_ctrl dacu_checker #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cmd_valid(cmd_valid),
  .cmd_word(cmd_word), .ld_low(ld_low), .act_flat(act_flat),
  .upd_pulse(upd_pulse), .chain_mode(chain_mode)
);

// File: tb/tb_dac_update_ctrl.sv
`timescale 1ns/1ps
module tb_dac_update_ctrl;
  localparam int NCH = 8;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [23:0]   cmd_word;
  logic          frame_sel;
  logic          load_n;
  logic [NCH*DW-1:0] act_flat;
  logic [NCH-1:0] upd_pulse;
  logic          chain_mode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_en = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  dac_update_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .frame_sel(frame_sel), .load_n(load_n), .act_flat(act_flat),
    .upd_pulse(upd_pulse), .chain_mode(chain_mode)
  );

  typedef struct {
    int               due;
    logic [NCH*DW-1:0] act;
    logic [NCH-1:0]    pulse;
    logic              chain;
    string             tag;
  } exp_t;
  exp_t sbq[$];

  // reference model built from the requirements
  logic [DW-1:0] m_stage [NCH];
  logic [DW-1:0] m_live  [NCH];
  logic          m_chain, m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin m_stage[i] = '0; m_live[i] = '0; end
      m_chain = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      logic ldl; logic [3:0] op, ch; logic [15:0] dt; exp_t e;
      cyc++;
      ldl = !m_s2; m_s2 = m_s1; m_s1 = load_n;
      op = cmd_word[23:20]; ch = cmd_word[19:16]; dt = cmd_word[15:0];
      e.pulse = '0;
      for (int i = 0; i < NCH; i++) begin
        logic [DW-1:0] nv;
        nv = m_live[i];
        if (ldl && frame_sel) nv = m_stage[i];                       // R6
        if (cmd_valid && op == 4'h2 && dt[i]) nv = m_stage[i];        // R4
        if (cmd_valid && op == 4'h1 && ch == 4'(i) && ldl) nv = dt;   // R3
        if (cmd_valid && op == 4'h3 && ch == 4'(i)) nv = dt;          // R5
        if (cmd_valid && op == 4'h1 && ch == 4'(i)) m_stage[i] = dt;  // R2
        e.pulse[i] = (nv != m_live[i]);                               // R10
        m_live[i] = nv;
      end
      if (cmd_valid && op == 4'h8) m_chain = dt[0];                   // R7
      for (int i = 0; i < NCH; i++) e.act[i*DW +: DW] = m_live[i];
      e.chain = m_chain; e.due = cyc; e.tag = phase;
      if (mon_en) sbq.push_back(e);
    end
  end

  // monitor
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (act_flat !== e.act || upd_pulse !== e.pulse || chain_mode !== e.chain) begin
        errors++;
        $display("FAIL %s cyc %0d act=%h pulse=%b chain=%b exp act=%h pulse=%b chain=%b",
                 e.tag, cyc, act_flat, upd_pulse, chain_mode, e.act, e.pulse, e.chain);
      end
    end
  end

  task automatic send(input logic [3:0] op, input logic [3:0] ch, input logic [15:0] dt);
    @(negedge clk);
    cmd_valid = 1; cmd_word = {op, ch, dt};
    @(negedge clk);
    cmd_valid = 0; cmd_word = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_word = '0; frame_sel = 1; load_n = 1;
    idle(3);
    rst_n = 1;
    idle(4);
    checks++;
    if (act_flat !== '0 || upd_pulse !== '0 || chain_mode !== 0) begin
      errors++;
      $display("FAIL R1 act=%h pulse=%b chain=%b exp all zero", act_flat, upd_pulse, chain_mode);
    end
    mon_en = 1;

    phase = "R2";
    for (int i = 0; i < NCH; i++) send(4'h1, 4'(i), 16'h1000 + 16'(i * 16'h0111));
    idle(2);
    phase = "R4";
    send(4'h2, 4'h0, 16'h0008);
    send(4'h2, 4'h0, 16'h00A5);
    send(4'h2, 4'h0, 16'h0000);
    send(4'h2, 4'h0, 16'h00FF);
    phase = "R10";
    send(4'h2, 4'h0, 16'h00FF);
    send(4'h3, 4'h2, 16'h1222);
    phase = "R5";
    send(4'h3, 4'h5, 16'hBEEF);
    send(4'h3, 4'h7, 16'h0000);
    phase = "R8";
    send(4'h1, 4'h9, 16'hDEAD);
    send(4'h3, 4'hF, 16'hDEAD);
    send(4'h2, 4'h0, 16'h00FF);
    phase = "R9";
    send(4'h0, 4'h1, 16'hFFFF);
    send(4'h4, 4'h2, 16'hFFFF);
    send(4'hF, 4'h3, 16'hFFFF);
    send(4'h9, 4'h0, 16'h0001);
    phase = "R7";
    send(4'h8, 4'h0, 16'h0003);
    send(4'h8, 4'h0, 16'h0002);
    send(4'h8, 4'h0, 16'h0001);

    phase = "R3";
    frame_sel = 0;
    for (int i = 0; i < NCH; i++) send(4'h1, 4'(i), 16'h5A00 + 16'(i));
    @(negedge clk); load_n = 0;
    idle(4);
    send(4'h1, 4'h4, 16'h7777);
    send(4'h3, 4'h6, 16'h6666);
    phase = "R6";
    @(negedge clk); frame_sel = 1;
    idle(2);
    @(negedge clk); frame_sel = 0; load_n = 1;
    idle(4);
    phase = "R11";
    for (int i = 0; i < NCH; i++) send(4'h1, 4'(i), 16'hC000 + 16'(i));
    @(negedge clk); frame_sel = 1; load_n = 0;
    @(negedge clk); load_n = 1;
    idle(6);
    @(negedge clk); load_n = 0;
    idle(1);
    send(4'h1, 4'h1, 16'h9999);
    @(negedge clk); load_n = 1;
    idle(5);

    mon_en = 0;
    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%h exp completion", act_flat);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule